// File: doc/BRIEF.md
# Timer 2 Capture/Reload Counter

This block is a 16-bit timer/counter with a 16-bit companion register that serves either as a capture latch or as a reload source. Its count source is either a machine-cycle tick, for timing, or falling edges on an external count pin, for event counting. An external control pin can snapshot the running count into the companion register in capture mode. In auto-reload mode the same pin forces a reload.

A third mode turns the block into a baud-rate generator. The count then advances every two system clocks. On each overflow it reloads from the companion register and emits a one-clock pulse for a serial port.

Software reaches the count bytes, the companion bytes and a control register over a simple byte-wide register bus. Writes take effect on the clock edge and reads are combinational. Two sticky flags, overflow and external, are raised by hardware. Only software writes lower them.

Top module: `t2_timer`

## Requirements
- R1: After reset the count, the companion register and the control register read 0, and `ovf_flag`, `ext_flag` and `baud_pulse` are low.
- R2: Bus address 0 is the count low byte, 1 is the count high byte, 2 is the companion low byte, 3 is the companion high byte and 4 is the control register. A write is visible on `bus_rdata` in the following cycle. A write to a count byte wins over a count step in the same cycle.
- R3: With control bit 1 (source select) at 0 and control bit 2 (run) at 1, the count rises by one for every cycle in which `cyc_tick` is high. With run at 0 the count holds.
- R4: With source select at 1, each falling edge of `cnt_pin` adds one to the count within four clocks, and `cyc_tick` has no effect.
- R5: In auto-reload mode (control bit 0 = 0, bit 5 = 0), a step from 0xFFFF loads the count from the companion register and sets the overflow flag (control bit 7, also `ovf_flag`).
- R6: In capture mode (control bit 0 = 1), a step from 0xFFFF wraps the count to 0 and sets the overflow flag.
- R7: In capture mode with control bit 3 (external enable) at 1, a falling edge of `ctl_pin` copies the count into the companion register and sets the external flag (control bit 6, also `ext_flag`). With external enable at 0 the edge changes nothing.
- R8: In auto-reload mode with external enable at 1, a falling edge of `ctl_pin` loads the count from the companion register and sets the external flag.
- R9: With control bit 5 (baud) at 1 and source select at 0, the count steps every second clock and reloads from the companion register on overflow. Each overflow gives exactly one single-clock `baud_pulse`, and the overflow flag is not set.
- R10: The flags are cleared only by a control write that holds them at 0. A hardware set in the same cycle as such a write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_tick | input | 1 | One-clock machine-cycle strobe |
| cnt_pin | input | 1 | External count input, asynchronous |
| ctl_pin | input | 1 | External capture/reload control, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| ovf_flag | output | 1 | Sticky overflow flag |
| ext_flag | output | 1 | Sticky external event flag |
| baud_pulse | output | 1 | One-clock pulse per baud-mode overflow |

## Verification
The bench drives the count to 0xFFFF and the steps just before it, in each mode. If the reload and wrap paths were swapped, capture mode would jump to the companion value instead of 0, and auto-reload mode would restart at 0. In baud mode it counts pulses over an exact window of periods. A design that set the overflow flag there, stretched the pulse, or stepped every clock would give the wrong pulse count or a raised flag.

It also places a flag-clearing write in the same cycle as an overflow step. A design that let software win would lose that event. It also confirms that the control-pin edge does nothing while external enable is low, and that a write to a count byte wins over a step in the same cycle.

// File: rtl/t2_pkg.sv
package t2_pkg;
  localparam int T2_AW = 3;

  localparam logic [T2_AW-1:0] A_CNT_LO  = 3'd0;
  localparam logic [T2_AW-1:0] A_CNT_HI  = 3'd1;
  localparam logic [T2_AW-1:0] A_CMP_LO  = 3'd2;
  localparam logic [T2_AW-1:0] A_CMP_HI  = 3'd3;
  localparam logic [T2_AW-1:0] A_CTRL    = 3'd4;

  // control register, bit 7 down to bit 0
  typedef struct packed {
    logic ovf;    // 7 sticky overflow
    logic ext;    // 6 sticky external event
    logic baud;   // 5 baud generator mode
    logic spare;  // 4 plain storage
    logic exen;   // 3 external pin enable
    logic run;    // 2 run control
    logic ext_src;// 1 count external pin when set
    logic capm;   // 0 capture mode when set, reload when clear
  } t2_ctrl_t;
endpackage

// File: rtl/t2_edge_sync.sv
module t2_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      last_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], pin};
      last_q <= sh_q[STAGES-1];
    end
  end

  assign fall = last_q & ~sh_q[STAGES-1];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall); // R4
endmodule

// File: rtl/t2_rate_div.sv
module t2_rate_div #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  generate
    if (DIV > 1) begin : g_div
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (cnt_q == CW'(DIV - 1)) cnt_q <= '0;
        else                            cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == CW'(DIV - 1));

      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R9
    end else begin : g_pass
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= '0;
      end
      assign tick = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/t2_timer.sv
module t2_timer
  import t2_pkg::*;
#(
  parameter int BW        = 8,
  parameter int SYNC      = 2,
  parameter int BAUD_DIV  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cyc_tick,
  input  logic                cnt_pin,
  input  logic                ctl_pin,
  input  logic                bus_wr,
  input  logic [T2_AW-1:0]    bus_addr,
  input  logic [BW-1:0]       bus_wdata,
  output logic [BW-1:0]       bus_rdata,
  output logic                ovf_flag,
  output logic                ext_flag,
  output logic                baud_pulse
);
  localparam int CW = 2 * BW;

  function automatic logic [CW:0] step_fn(input logic [CW-1:0] v);
    return {1'b0, v} + {{CW{1'b0}}, 1'b1};
  endfunction

  t2_ctrl_t        ctrl_q, ctrl_d;
  logic [CW-1:0]   cnt_q, cnt_d, cmp_q, cmp_d;
  logic            baud_q;

  // named internal events
  logic cnt_fall, ctl_fall, half_tick;
  logic src_tick, step, carry, ovf_evt, ext_evt, cap_evt, rld_evt;
  logic wr_cnt_lo, wr_cnt_hi, wr_cmp_lo, wr_cmp_hi, wr_ctrl;
  logic [CW:0] inc;

  t2_edge_sync #(.STAGES(SYNC)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .fall(cnt_fall));

  t2_edge_sync #(.STAGES(SYNC)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .pin(ctl_pin), .fall(ctl_fall));

  t2_rate_div #(.DIV(BAUD_DIV)) u_baud_div (
    .clk(clk), .rst_n(rst_n), .tick(half_tick));

  assign wr_cnt_lo = bus_wr && (bus_addr == A_CNT_LO);
  assign wr_cnt_hi = bus_wr && (bus_addr == A_CNT_HI);
  assign wr_cmp_lo = bus_wr && (bus_addr == A_CMP_LO);
  assign wr_cmp_hi = bus_wr && (bus_addr == A_CMP_HI);
  assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);

  always_comb begin
    if (ctrl_q.ext_src)   src_tick = cnt_fall;
    else if (ctrl_q.baud) src_tick = half_tick;
    else                  src_tick = cyc_tick;
  end

  assign step    = ctrl_q.run && src_tick;
  assign inc     = step_fn(cnt_q);
  assign carry   = inc[CW];
  assign ovf_evt = step && carry;
  assign ext_evt = ctrl_q.exen && ctl_fall;
  assign cap_evt = ext_evt && ctrl_q.capm && !ctrl_q.baud;
  assign rld_evt = ext_evt && !ctrl_q.capm && !ctrl_q.baud;

  // count path
  always_comb begin
    cnt_d = cnt_q;
    if (step) begin
      if (!carry)                            cnt_d = inc[CW-1:0];
      else if (ctrl_q.baud || !ctrl_q.capm)  cnt_d = cmp_q;
      else                                   cnt_d = '0;
    end
    if (rld_evt) cnt_d = cmp_q;
    if (wr_cnt_lo) cnt_d[BW-1:0]  = bus_wdata;
    if (wr_cnt_hi) cnt_d[CW-1:BW] = bus_wdata;
  end

  // companion path
  always_comb begin
    cmp_d = cmp_q;
    if (cap_evt)   cmp_d = cnt_q;
    if (wr_cmp_lo) cmp_d[BW-1:0]  = bus_wdata;
    if (wr_cmp_hi) cmp_d[CW-1:BW] = bus_wdata;
  end

  // control path: software write first, hardware set on top
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = t2_ctrl_t'(bus_wdata[7:0]);
    if (ovf_evt && !ctrl_q.baud) ctrl_d.ovf = 1'b1;
    if (ext_evt)                 ctrl_d.ext = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmp_q  <= '0;
      ctrl_q <= '0;
      baud_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cmp_q  <= cmp_d;
      ctrl_q <= ctrl_d;
      baud_q <= ovf_evt && ctrl_q.baud;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CNT_LO: bus_rdata = cnt_q[BW-1:0];
      A_CNT_HI: bus_rdata = cnt_q[CW-1:BW];
      A_CMP_LO: bus_rdata = cmp_q[BW-1:0];
      A_CMP_HI: bus_rdata = cmp_q[CW-1:BW];
      A_CTRL:   bus_rdata = BW'(ctrl_q);
      default:  bus_rdata = '0;
    endcase
  end

  assign ovf_flag   = ctrl_q.ovf;
  assign ext_flag   = ctrl_q.ext;
  assign baud_pulse = baud_q;

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !rld_evt && !wr_cnt_lo && !wr_cnt_hi) |=> $stable(cnt_q)); // R3

  AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !ctrl_q.baud && !ctrl_q.capm && !wr_cnt_lo && !wr_cnt_hi
     && !wr_cmp_lo && !wr_cmp_hi && !wr_ctrl)
    |=> (cnt_q == $past(cmp_q)) && ovf_flag); // R5

  AST_CAPTURE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && ctrl_q.capm && !ctrl_q.baud && !wr_cnt_lo && !wr_cnt_hi && !wr_ctrl)
    |=> (cnt_q == '0) && ovf_flag); // R6

  AST_CAPTURE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && !wr_cmp_lo && !wr_cmp_hi) |=> (cmp_q == $past(cnt_q)) && ext_flag); // R7

  AST_BAUD_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.baud && !wr_ctrl) |=> !$rose(ovf_flag)); // R9

  AST_BAUD_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    baud_pulse |=> !baud_pulse); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !wr_ctrl) |=> ovf_flag); // R10
endmodule

// File: tb/t2_timer_bench.sv
`timescale 1ns/1ps
module t2_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_tick = 1'b0;
  logic       cnt_pin = 1'b1;
  logic       ctl_pin = 1'b1;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ovf_flag, ext_flag, baud_pulse;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  t2_timer u_t2_timer (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .cnt_pin(cnt_pin),
    .ctl_pin(ctl_pin), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_flag(ovf_flag),
    .ext_flag(ext_flag), .baud_pulse(baud_pulse));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd16(input logic [2:0] a_lo, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a_lo, lo);
    rd(a_lo + 3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic wr16(input logic [2:0] a_lo, input logic [15:0] v);
    wr(a_lo, v[7:0]);
    wr(a_lo + 3'd1, v[15:8]);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cyc_tick = 1'b1;
      @(negedge clk); cyc_tick = 1'b0;
    end
  endtask

  task automatic pin_fall(input bit ctl);
    @(negedge clk);
    if (ctl) ctl_pin = 1'b0; else cnt_pin = 1'b0;
    repeat (6) @(negedge clk);
    if (ctl) ctl_pin = 1'b1; else cnt_pin = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    logic [7:0]  c;
    rd16(3'd0, v); check("R1 count", v, 0);
    rd16(3'd2, v); check("R1 companion", v, 0);
    rd(3'd4, c);   check("R1 control", c, 0);
    check("R1 outputs", {ovf_flag, ext_flag, baud_pulse}, 0);
  endtask

  task automatic t_bus();
    logic [15:0] v;
    wr16(3'd2, 16'hA55A);
    rd16(3'd2, v); check("R2 companion rw", v, 16'hA55A);
    wr16(3'd0, 16'h0010);
    wr(3'd4, 8'h04);              // run, timer source
    @(negedge clk);
    cyc_tick = 1'b1; bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h80;
    @(negedge clk);
    cyc_tick = 1'b0; bus_wr = 1'b0;
    rd16(3'd0, v); check("R2 write wins over step", v, 16'h0080);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_timer();
    logic [15:0] v;
    wr16(3'd0, 16'h0100);
    wr(3'd4, 8'h04);
    ticks(5);
    rd16(3'd0, v); check("R3 timer counts ticks", v, 16'h0105);
    wr(3'd4, 8'h00);
    ticks(3);
    rd16(3'd0, v); check("R3 stopped holds", v, 16'h0105);
  endtask

  task automatic t_counter();
    logic [15:0] v;
    wr16(3'd0, 16'h0200);
    wr(3'd4, 8'h06);              // run + external source
    pin_fall(1'b0); pin_fall(1'b0); pin_fall(1'b0);
    rd16(3'd0, v); check("R4 pin edges counted", v, 16'h0203);
    ticks(4);
    rd16(3'd0, v); check("R4 cyc_tick ignored", v, 16'h0203);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_reload();
    logic [15:0] v;
    wr16(3'd2, 16'h1234);
    wr16(3'd0, 16'hFFFE);
    wr(3'd4, 8'h04);
    ticks(1);
    check("R5 no flag before wrap", ovf_flag, 0);
    ticks(1);
    rd16(3'd0, v); check("R5 reload value", v, 16'h1234);
    check("R5 ovf flag", ovf_flag, 1);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_capture_wrap();
    logic [15:0] v;
    wr16(3'd2, 16'h4321);
    wr16(3'd0, 16'hFFFF);
    wr(3'd4, 8'h05);
    ticks(1);
    rd16(3'd0, v); check("R6 wrap to zero", v, 0);
    check("R6 ovf flag", ovf_flag, 1);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_capture_pin();
    logic [15:0] v;
    wr16(3'd2, 16'h0000);
    wr16(3'd0, 16'h0042);
    wr(3'd4, 8'h01);              // capture mode, enable off
    pin_fall(1'b1);
    rd16(3'd2, v); check("R7 disabled edge no capture", v, 0);
    check("R7 disabled edge no flag", ext_flag, 0);
    wr(3'd4, 8'h09);              // capture mode + enable
    pin_fall(1'b1);
    rd16(3'd2, v); check("R7 captured value", v, 16'h0042);
    check("R7 ext flag", ext_flag, 1);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_reload_pin();
    logic [15:0] v;
    wr16(3'd2, 16'hBEEF);
    wr16(3'd0, 16'h0007);
    wr(3'd4, 8'h08);              // reload mode + enable
    pin_fall(1'b1);
    rd16(3'd0, v); check("R8 pin reload", v, 16'hBEEF);
    check("R8 ext flag", ext_flag, 1);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_baud();
    int pulses = 0;
    int dbl = 0;
    logic prev = 1'b0;
    wr16(3'd2, 16'hFFF0);
    wr16(3'd0, 16'hFFF0);
    wr(3'd4, 8'h24);              // baud + run
    repeat (40) @(negedge clk);
    for (int i = 0; i < 160; i++) begin
      @(negedge clk);
      if (baud_pulse) pulses++;
      if (baud_pulse && prev) dbl++;
      prev = baud_pulse;
    end
    check("R9 pulse count per window", pulses, 5);
    check("R9 single-clock pulse", dbl, 0);
    check("R9 no ovf flag", ovf_flag, 0);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_flags();
    logic [15:0] v;
    wr16(3'd0, 16'hFFFF);
    wr(3'd4, 8'hC5);              // both flags set by software, capture, run
    wr(3'd4, 8'h05);
    check("R10 software clear ovf", ovf_flag, 0);
    check("R10 software clear ext", ext_flag, 0);
    wr(3'd4, 8'h85);
    @(negedge clk);
    cyc_tick = 1'b1; bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h05;
    @(negedge clk);
    cyc_tick = 1'b0; bus_wr = 1'b0;
    check("R10 hardware set wins", ovf_flag, 1);
    rd16(3'd0, v); check("R10 wrap during clear", v, 0);
    wr(3'd4, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bus();
    t_timer();
    t_counter();
    t_reload();
    t_capture_wrap();
    t_capture_pin();
    t_reload_pin();
    t_baud();
    t_flags();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule